// File: doc/BRIEF.md
# Serial Sampling-Converter Interface Model

This block models, in synthesizable logic, the digital side of a 16-bit sampling converter that is read over a three-wire serial link. A host drives an active-low select and a serial clock. The block sends back one frame on a single data line. A parallel word stands in for the analog input. The word held at the moment the sample is frozen is treated as the conversion result and is sent unchanged, as straight unipolar binary: code zero is zero scale and all ones is full scale.

Both host signals are asynchronous to the block. Each passes through a synchronizer into a faster system clock, and the block acts only on edges it detects there. When select falls, the block leaves power-down and drives the line low. Each falling serial-clock edge advances a frame counter. The sample is frozen on a fixed falling edge. A run of zero bits goes out first, then the data word with its most significant bit first. Once the counter reaches the end of the frame it saturates, and the line stays at zero. Raising select at any point returns the block to power-down and clears its state.

Top module: `sar_serial_port`

## Requirements
- R1: While reset is high and afterwards until select falls, `pwr_down` is 1, `sdo_oe` is 0 and `sdo` is 0.
- R2: Whenever `cs_n` is high, within 3 system clocks `sdo_oe` is 0 (line released) and `pwr_down` is 1.
- R3: After a falling edge on `cs_n`, within 3 system clocks `sdo_oe` is 1, `sdo` is 0 and `pwr_down` is 0.
- R4: `sample_word` is captured on the CAPTURE_EDGE-th falling `sclk` edge of a frame (default 6th). Its value before and after that edge has no effect on the bits sent.
- R5: Before the first falling `sclk` edge and after falling edges 1 to LEAD_BITS-1, `sdo` is 0, so LEAD_BITS zero bits (default 8) precede the data.
- R6: After falling edge n, for LEAD_BITS <= n < LEAD_BITS+DATA_W, `sdo` equals bit DATA_W-1-(n-LEAD_BITS) of the captured word. The word is sent MSB first, unmodified, as straight binary, and 0 and all ones are sent as such.
- R7: After falling edge LEAD_BITS+DATA_W (default 24) and any further falling edges with `cs_n` low, `sdo` is 0 and the frame does not restart.
- R8: `sdo` changes only in response to a falling `sclk` edge or a `cs_n` edge. Rising `sclk` edges leave it unchanged.
- R9: Raising `cs_n` part-way through a frame ends it at once: the line is released, `pwr_down` is 1, and the next frame starts from edge count zero with a new capture.
- R10: `sdo` reflects a falling `sclk` edge exactly 3 system clocks after the edge: 2 synchronizer flops plus the frame counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, idles low, asynchronous |
| sample_word | input | DATA_W | Parallel word taken as the conversion result |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | 1 = drive `sdo` onto the line, 0 = high impedance |
| pwr_down | output | 1 | 1 while in power-down |

## Verification
The bench builds the block with DATA_W = 8, LEAD_BITS = 4 and CAPTURE_EDGE = 3. With these values every one of the 256 input words can be sent through a full frame plus trailing edges. The sample word is flipped on both sides of the capture edge, which makes any early or late capture visible. The small frame also leaves room for aborts before and after the capture point, and for a cycle-exact probe of the three-clock edge latency.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic {
        PH_SHUTDOWN = 1'b0,
        PH_ACTIVE   = 1'b1
    } phase_e;

    typedef struct packed {
        logic level;
        logic fall;
    } edge_ev_t;

    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync
    import sar_port_pkg::*;
#(
    parameter int               LANES    = 2,
    parameter int               STAGES   = 2,
    parameter logic [LANES-1:0] IDLE_VAL = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LANES-1:0]     async_in,
    output edge_ev_t [LANES-1:0] ev
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [STAGES-1:0] pipe;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= {STAGES{IDLE_VAL[i]}};
                prev <= IDLE_VAL[i];
            end else begin
                pipe <= {pipe[STAGES-2:0], async_in[i]};
                prev <= pipe[STAGES-1];
            end
        end

        assign ev[i].level = pipe[STAGES-1];
        assign ev[i].fall  = prev & ~pipe[STAGES-1];
    end

endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
    import sar_port_pkg::*;
#(
    parameter int FRAME_LEN    = 24,
    parameter int CAPTURE_EDGE = 6,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_lvl,
    input  logic             cs_fall,
    input  logic             sclk_fall,
    output phase_e           phase,
    output logic [CNT_W-1:0] count,
    output logic             cap_stb
);

    localparam logic [CNT_W-1:0] FRAME_C   = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] PRE_CAP_C = CNT_W'(CAPTURE_EDGE - 1);

    logic step;

    assign step    = (phase == PH_ACTIVE) && !cs_lvl && sclk_fall;
    assign cap_stb = step && (count == PRE_CAP_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SHUTDOWN;
            count <= '0;
        end else if (cs_lvl) begin
            phase <= PH_SHUTDOWN;
            count <= '0;
        end else if (cs_fall) begin
            phase <= PH_ACTIVE;
            count <= '0;
        end else if (step && (count != FRAME_C)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift
    import sar_port_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int LEAD_BITS = 8,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  count,
    input  logic              cap_stb,
    input  logic [DATA_W-1:0] sample_word,
    output logic [DATA_W-1:0] held,
    output logic              sdo
);

    localparam int               FRAME_LEN = LEAD_BITS + DATA_W;
    localparam int               IDX_W     = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LEAD_C    = CNT_W'(LEAD_BITS);
    localparam logic [CNT_W-1:0] FRAME_C   = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_C    = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] pos;
    logic             in_data;

    always_ff @(posedge clk) begin
        if (rst || phase == PH_SHUTDOWN) begin
            held <= '0;
        end else if (cap_stb) begin
            held <= sample_word;
        end
    end

    assign pos     = LAST_C - count;
    assign in_data = (phase == PH_ACTIVE) && (count >= LEAD_C) && (count < FRAME_C);
    assign sdo     = in_data ? held[pos[IDX_W-1:0]] : 1'b0;

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
    import sar_port_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int LEAD_BITS    = 8,
    parameter int CAPTURE_EDGE = 6,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              pwr_down
);

    localparam int FRAME_LEN = LEAD_BITS + DATA_W;
    localparam int CNT_W     = cnt_bits(FRAME_LEN);

    edge_ev_t [1:0]    ev;
    logic              cs_lvl;
    logic              cs_fall;
    logic              sclk_fall;
    logic              unused_sclk_lvl;
    phase_e            phase;
    logic [CNT_W-1:0]  frame_cnt;
    logic              cap_stb;
    logic [DATA_W-1:0] held_word;

    sar_edge_sync #(
        .LANES   (2),
        .STAGES  (SYNC_STAGES),
        .IDLE_VAL(2'b01)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in({sclk, cs_n}),
        .ev      (ev)
    );

    assign cs_lvl          = ev[0].level;
    assign cs_fall         = ev[0].fall;
    assign sclk_fall       = ev[1].fall;
    assign unused_sclk_lvl = ev[1].level;

    sar_frame_ctrl #(
        .FRAME_LEN   (FRAME_LEN),
        .CAPTURE_EDGE(CAPTURE_EDGE),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cs_lvl   (cs_lvl),
        .cs_fall  (cs_fall),
        .sclk_fall(sclk_fall),
        .phase    (phase),
        .count    (frame_cnt),
        .cap_stb  (cap_stb)
    );

    sar_out_shift #(
        .DATA_W   (DATA_W),
        .LEAD_BITS(LEAD_BITS),
        .CNT_W    (CNT_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .count      (frame_cnt),
        .cap_stb    (cap_stb),
        .sample_word(sample_word),
        .held       (held_word),
        .sdo        (sdo)
    );

    assign sdo_oe   = (phase == PH_ACTIVE);
    assign pwr_down = (phase == PH_SHUTDOWN);

endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
    parameter int DATA_W    = 16,
    parameter int LEAD_BITS = 8,
    parameter int CNT_W     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_lvl,
    input logic              cs_fall,
    input logic              sclk_fall,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] held,
    input logic [DATA_W-1:0] sample,
    input logic              cap,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              pwr_down
);

    localparam logic [CNT_W-1:0] LEAD_C  = CNT_W'(LEAD_BITS);
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(LEAD_BITS + DATA_W);

    // R2
    shutdown_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cs_lvl |=> (!sdo_oe && pwr_down));

    // R3
    start_drive_chk: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (sdo_oe && !sdo && !pwr_down));

    // R4
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> (held == $past(sample)));

    // R4
    held_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && !cap && !cs_lvl) |=> $stable(held));

    // R5
    lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && cnt < LEAD_C) |-> !sdo);

    // R7
    trail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && cnt == FRAME_C) |-> !sdo);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FRAME_C);

    // R8
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && !sclk_fall && !cs_lvl) |=> $stable(sdo));

    // R9
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && cs_lvl) |=> (cnt == '0));

endmodule

bind sar_serial_port sar_serial_port_chk #(
    .DATA_W   (DATA_W),
    .LEAD_BITS(LEAD_BITS),
    .CNT_W    (CNT_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_lvl   (cs_lvl),
    .cs_fall  (cs_fall),
    .sclk_fall(sclk_fall),
    .cnt      (frame_cnt),
    .held     (held_word),
    .sample   (sample_word),
    .cap      (cap_stb),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .pwr_down (pwr_down)
);

// File: tb/test_sar_serial_port.sv
module test_sar_serial_port;

    localparam int DW  = 8;
    localparam int LZ  = 4;
    localparam int CAP = 3;
    localparam int FR  = LZ + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic [DW-1:0] sample_word = '0;
    logic          sdo;
    logic          sdo_oe;
    logic          pwr_down;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sar_serial_port #(
        .DATA_W      (DW),
        .LEAD_BITS   (LZ),
        .CAPTURE_EDGE(CAP),
        .SYNC_STAGES (2)
    ) i_sar_serial_port (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sample_word(sample_word),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .pwr_down   (pwr_down)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        chk(req, {31'd0, sdo_oe}, 32'd0);
        chk(req, {31'd0, pwr_down}, 32'd1);
        chk(req, {31'd0, sdo}, 32'd0);
    endtask

    // abort_after < 0 runs the whole frame plus two trailing edges
    task automatic run_frame(input logic [DW-1:0] word, input int abort_after);
        logic prev;
        logic exp;
        sample_word = ~word;
        cs_n = 1'b0;
        settle();
        chk("R3", {29'd0, sdo_oe, pwr_down, sdo}, 32'b100);
        for (int n = 1; n <= FR + 2; n++) begin
            if (n == CAP) sample_word = word;
            prev = sdo;
            sclk = 1'b1;
            settle();
            chk("R8", {31'd0, sdo}, {31'd0, prev});
            sclk = 1'b0;
            settle();
            if (n == CAP) sample_word = ~word;
            if (n < LZ) begin
                chk("R5", {31'd0, sdo}, 32'd0);
            end else if (n < FR) begin
                exp = word[DW - 1 - (n - LZ)];
                chk("R6", {31'd0, sdo}, {31'd0, exp});
            end else begin
                chk("R7", {31'd0, sdo}, 32'd0);
            end
            if (n == abort_after) break;
        end
        cs_n = 1'b1;
        settle();
        if (abort_after >= 0) check_idle("R9");
        else check_idle("R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        settle();
        check_idle("R1");

        // R4 R5 R6 R7 R8: every word of the small configuration
        for (int w = 0; w < (1 << DW); w++) begin
            run_frame(DW'(w), -1);
        end

        // R9: abort before and after the capture edge, then a clean frame
        run_frame(8'hFF, CAP - 1);
        run_frame(8'h3C, -1);
        run_frame(8'hFF, LZ + 2);
        run_frame(8'h81, -1);

        // R10: exact three-clock latency from a falling sclk edge
        sample_word = '1;
        cs_n = 1'b0;
        settle();
        for (int n = 1; n < LZ; n++) begin
            sclk = 1'b1; settle();
            sclk = 1'b0; settle();
        end
        sclk = 1'b1; settle();
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", {31'd0, sdo}, 32'd0);
        @(negedge clk);
        chk("R10", {31'd0, sdo}, 32'd1);
        cs_n = 1'b1;
        settle();
        check_idle("R2");

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule